// File: doc/BRIEF.md
# Scrollable Text Window Address Generator

This block turns the visible character position reported by the display timing into a screen-memory address. The visible window is 40 columns by 25 rows. It views a larger plane of 80 columns by 50 rows. Software sets horizontal and vertical scroll offsets through a small write port. The block adds them to the visible position and forms the linear address as row-sum times 80 plus column-sum. The multiply by 80 is built from a shift by six plus a shift by four, so no multiplier is needed.

The same block also flags when the current character cell holds the hardware cursor. The cursor has a position in plane coordinates, a shape (the full cell, or only the last scan line of the 8-line cell), and a blink period counted in frames. The scroll offsets only take effect at a frame boundary, so a scroll never splits a picture. The cursor settings take effect at once.

Top module: `txtwin_addr`

## Requirements
- R1: After reset `mem_addr` and `cursor_on` are 0. Both offsets are 0, the cursor position is column 0 row 0, the shape is block, the blink period is 0 and the cursor is visible.
- R2: At a rising edge with `char_en` high, `mem_addr` takes (char_row + Yoff) * 80 + char_col + Xoff, using the offsets currently in force. The new value is visible after that edge.
- R3: While `char_en` is low, `mem_addr` and `cursor_on` keep their values.
- R4: A write of a value above 40 to the X offset stores 40. A write of a value above 25 to the Y offset stores 25.
- R5: Offset writes take effect only at the first rising edge with `frame_start` high after the write. Before that edge, addresses use the previous offsets.
- R6: In block shape (shape bit 0 = 0), `cursor_on` is set on every scan line when char_col + Xoff equals the cursor column, char_row + Yoff equals the cursor row, and the cursor is in its visible blink phase.
- R7: `cursor_on` is never set for a character with char_col >= 40 or char_row >= 25, even when the plane position matches.
- R8: In line shape (shape bit 0 = 1), `cursor_on` is set only when `scan_line` is 7.
- R9: With blink period N > 0, the visible phase toggles after every N `frame_start` pulses. With N = 0, the cursor is always in the visible phase.
- R10: Writes are decoded by `wr_sel`: 0 X offset, 1 Y offset, 2 cursor column, 3 cursor row, 4 blink period, 5 shape. Writes with codes 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| char_en | input | 1 | Character clock enable |
| char_col | input | 7 | Visible character column |
| char_row | input | 6 | Visible character row |
| scan_line | input | 3 | Scan line within the character cell |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 8 | Register write data |
| mem_addr | output | 12 | Screen-memory address |
| cursor_on | output | 1 | Cursor overlay active for this cell |

## Verification
The bench uses the default geometry: a 40x25 window over an 80x50 plane, 8-line cells and a 12-bit address. This lets the largest offsets reach address 3999, the last cell of the plane, and shows that it still fits in 12 bits. A blink period of 2 lets the bench see a full off-and-on blink cycle within a few frame pulses. The bench also places the cursor at plane columns that can only be matched from outside the visible window, to exercise the window gating.

// File: rtl/txtwin_addr.sv
module txtwin_addr #(
  parameter int VIS_COLS   = 40,
  parameter int VIS_ROWS   = 25,
  parameter int PLANE_ROWS = 50,
  parameter int CELL_LINES = 8,
  parameter int ADDR_W     = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_start,
  input  logic                          char_en,
  input  logic [6:0]                    char_col,
  input  logic [$clog2(PLANE_ROWS)-1:0] char_row,
  input  logic [$clog2(CELL_LINES)-1:0] scan_line,
  input  logic                          wr_en,
  input  logic [2:0]                    wr_sel,
  input  logic [7:0]                    wr_data,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic                          cursor_on
);
  // stride is fixed at 80 = 64 + 16, built from two shifts
  localparam int PLANE_COLS = 80;
  localparam int COL_W  = 7;
  localparam int ROW_W  = $clog2(PLANE_ROWS);
  localparam int LINE_W = $clog2(CELL_LINES);
  localparam int X_MAX  = PLANE_COLS - VIS_COLS;
  localparam int Y_MAX  = PLANE_ROWS - VIS_ROWS;

  logic [COL_W-1:0] xoff_new, xoff_act, cur_col, col_sum;
  logic [ROW_W-1:0] yoff_new, yoff_act, cur_row, row_sum;
  logic [7:0]       blink_n, blink_cnt;
  logic             line_mode, blink_vis;
  logic             in_win, shape_ok, hit;
  logic [ADDR_W-1:0] addr_next;

  assign col_sum   = char_col + xoff_act;
  assign row_sum   = char_row + yoff_act;
  assign addr_next = (ADDR_W'(row_sum) << 6) + (ADDR_W'(row_sum) << 4) + ADDR_W'(col_sum);
  assign in_win    = (char_col < COL_W'(VIS_COLS)) && (char_row < ROW_W'(VIS_ROWS));
  assign shape_ok  = !line_mode || (scan_line == LINE_W'(CELL_LINES - 1));
  assign hit       = in_win && shape_ok && blink_vis && (col_sum == cur_col) && (row_sum == cur_row);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xoff_new  <= '0;
      yoff_new  <= '0;
      cur_col   <= '0;
      cur_row   <= '0;
      blink_n   <= '0;
      line_mode <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: xoff_new  <= (wr_data > 8'(X_MAX)) ? COL_W'(X_MAX) : wr_data[COL_W-1:0];
        3'd1: yoff_new  <= (wr_data > 8'(Y_MAX)) ? ROW_W'(Y_MAX) : wr_data[ROW_W-1:0];
        3'd2: cur_col   <= wr_data[COL_W-1:0];
        3'd3: cur_row   <= wr_data[ROW_W-1:0];
        3'd4: blink_n   <= wr_data;
        3'd5: line_mode <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xoff_act  <= '0;
      yoff_act  <= '0;
      blink_cnt <= '0;
      blink_vis <= 1'b1;
    end else if (frame_start) begin
      xoff_act <= xoff_new;
      yoff_act <= yoff_new;
      if (blink_n == 8'd0) begin
        blink_cnt <= '0;
        blink_vis <= 1'b1;
      end else if (blink_cnt >= blink_n - 8'd1) begin
        blink_cnt <= '0;
        blink_vis <= !blink_vis;
      end else begin
        blink_cnt <= blink_cnt + 8'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      cursor_on <= 1'b0;
    end else if (char_en) begin
      mem_addr  <= addr_next;
      cursor_on <= hit;
    end
  end
endmodule

// File: rtl/txtwin_addr_chk.sv
module txtwin_addr_chk #(
  parameter int VIS_COLS   = 40,
  parameter int VIS_ROWS   = 25,
  parameter int PLANE_ROWS = 50,
  parameter int CELL_LINES = 8,
  parameter int ADDR_W     = 12
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          frame_start,
  input logic                          char_en,
  input logic [6:0]                    char_col,
  input logic [$clog2(PLANE_ROWS)-1:0] char_row,
  input logic [$clog2(CELL_LINES)-1:0] scan_line,
  input logic                          line_mode,
  input logic [6:0]                    xoff_act,
  input logic [$clog2(PLANE_ROWS)-1:0] yoff_act,
  input logic [ADDR_W-1:0]             mem_addr,
  input logic                          cursor_on
);
  localparam int PLANE_CELLS = 80 * PLANE_ROWS;

  // R4
  offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff_act <= 7'(80 - VIS_COLS)) && (yoff_act <= $bits(yoff_act)'(PLANE_ROWS - VIS_ROWS)));

  // R5
  offset_frame_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(xoff_act) && $stable(yoff_act));

  // R2
  addr_in_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_en && char_col < 7'(VIS_COLS) && char_row < $bits(char_row)'(VIS_ROWS))
    |=> (32'(mem_addr) < PLANE_CELLS));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !char_en |=> $stable(mem_addr) && $stable(cursor_on));

  // R7
  outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_en && (char_col >= 7'(VIS_COLS) || char_row >= $bits(char_row)'(VIS_ROWS))) |=> !cursor_on);

  // R8
  line_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_en && line_mode && scan_line != $bits(scan_line)'(CELL_LINES - 1)) |=> !cursor_on);
endmodule

bind txtwin_addr txtwin_addr_chk #(
  .VIS_COLS(VIS_COLS), .VIS_ROWS(VIS_ROWS), .PLANE_ROWS(PLANE_ROWS),
  .CELL_LINES(CELL_LINES), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .char_en(char_en),
  .char_col(char_col), .char_row(char_row), .scan_line(scan_line),
  .line_mode(line_mode), .xoff_act(xoff_act), .yoff_act(yoff_act),
  .mem_addr(mem_addr), .cursor_on(cursor_on)
);

// File: tb/txtwin_addr_tb_top.sv
module txtwin_addr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        char_en = 1'b0;
  logic [6:0]  char_col = '0;
  logic [5:0]  char_row = '0;
  logic [2:0]  scan_line = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [11:0] mem_addr;
  logic        cursor_on;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  txtwin_addr dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .char_en(char_en),
    .char_col(char_col), .char_row(char_row), .scan_line(scan_line),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mem_addr(mem_addr), .cursor_on(cursor_on)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic show(input int col, input int row, input int line);
    @(negedge clk);
    char_col = 7'(col); char_row = 6'(row); scan_line = 3'(line); char_en = 1'b1;
    @(negedge clk);
    char_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 addr", int'(mem_addr), 0);
    check("R1 cursor", int'(cursor_on), 0);
    show(0, 0, 0);
    check("R1 addr at origin", int'(mem_addr), 0);
    check("R1 R6 cursor at origin", int'(cursor_on), 1);
  endtask

  task automatic t_scroll();
    write_reg(0, 10);
    write_reg(1, 3);
    show(5, 2, 0);
    check("R5 old offsets used", int'(mem_addr), 2 * 80 + 5);
    frame();
    show(5, 2, 0);
    check("R2 offset address", int'(mem_addr), 5 * 80 + 15);
    show(39, 24, 0);
    check("R2 corner address", int'(mem_addr), 27 * 80 + 49);
  endtask

  task automatic t_hold();
    @(negedge clk);
    char_col = 7'd1; char_row = 6'd1;
    @(negedge clk);
    check("R3 hold addr", int'(mem_addr), 27 * 80 + 49);
    check("R3 hold cursor", int'(cursor_on), 0);
  endtask

  task automatic t_clamp();
    write_reg(0, 63);
    write_reg(1, 200);
    frame();
    show(39, 24, 0);
    check("R4 clamped max address", int'(mem_addr), 49 * 80 + 79);
  endtask

  task automatic t_ignore();
    write_reg(7, 5);
    write_reg(6, 0);
    frame();
    show(39, 24, 0);
    check("R10 unused selects", int'(mem_addr), 3999);
  endtask

  task automatic t_cursor();
    write_reg(2, 45);
    write_reg(3, 30);
    show(5, 5, 3);
    check("R6 block hit", int'(cursor_on), 1);
    show(6, 5, 3);
    check("R6 column miss", int'(cursor_on), 0);
    write_reg(0, 0);
    write_reg(1, 0);
    frame();
    write_reg(3, 2);
    show(45, 2, 3);
    check("R7 outside window", int'(cursor_on), 0);
    write_reg(2, 3);
    write_reg(3, 30);
    show(3, 30, 3);
    check("R7 row outside window", int'(cursor_on), 0);
  endtask

  task automatic t_line();
    write_reg(2, 3);
    write_reg(3, 2);
    write_reg(5, 1);
    show(3, 2, 3);
    check("R8 line mode mid cell", int'(cursor_on), 0);
    show(3, 2, 7);
    check("R8 line mode last line", int'(cursor_on), 1);
    write_reg(5, 0);
    show(3, 2, 0);
    check("R6 block first line", int'(cursor_on), 1);
  endtask

  task automatic t_blink();
    write_reg(4, 2);
    frame();
    show(3, 2, 0);
    check("R9 after 1 frame", int'(cursor_on), 1);
    frame();
    show(3, 2, 0);
    check("R9 after 2 frames", int'(cursor_on), 0);
    frame();
    show(3, 2, 0);
    check("R9 after 3 frames", int'(cursor_on), 0);
    frame();
    show(3, 2, 0);
    check("R9 after 4 frames", int'(cursor_on), 1);
    frame();
    frame();
    write_reg(4, 0);
    show(3, 2, 0);
    check("R9 still hidden before frame", int'(cursor_on), 0);
    frame();
    show(3, 2, 0);
    check("R9 period zero always on", int'(cursor_on), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_scroll();
    t_hold();
    t_clamp();
    t_ignore();
    t_cursor();
    t_line();
    t_blink();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule